// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer

This block is a watchdog timer for an SoC. Software keeps it from firing by writing a refresh key before a programmable time-out expires. Its settings can change only inside a short configuration window. Software opens that window with a two-word unlock sequence, and the window closes when a new time-out value is written. If the window runs out before that write, or an unlock word is wrong, the block raises a reset exactly as a time-out would.

The counter can advance on every bus-clock cycle or only on cycles where a low-power tick input is high. Separate control bits decide whether counting continues in wait mode, in stop mode and in debug mode. In debug the count freezes and later resumes, but the configuration window is still enforced there. While the bus clock is gated, the window timer pauses.

A time-out either requests reset directly or first raises an interrupt for a fixed delay. A saturating counter records how many such resets the block has issued. In stop mode the block behaves differently: a reset needs two full time-outs, no interrupt is raised, and the reset counter does not change.

Top module: `modewdt_top`

## Requirements
- R1: After reset the control register reads 0x0003 (bit 0 enable = 1, bit 1 bus-clock source = 1, bits 2..5 = 0). The time-out register reads TOVAL_RST. The reset counter and the live count read 0, and `irq` and `rst_req` are low.
- R2: With the bus-clock source, no wait, stop or debug mode, and interrupt disabled, `rst_req` goes high exactly T cycles after the edge that writes time-out value T (or after the refresh edge, data 0x7D9A at address 2). It stays high for exactly one cycle and `irq` stays low. A value of 0 acts as 1.
- R3: With bit 2 (interrupt enable) set, `irq` rises T cycles after the restart edge and stays high for IRQ_DLY cycles. `rst_req` pulses in the cycle in which `irq` falls.
- R4: Every reset issued outside stop mode adds one to the reset counter (address 4), which saturates at 2^RCNT_W-1. Writing 0xFFFF to address 4 clears the counter, and writing any other value leaves it unchanged.
- R5: Writes to control (address 0) and time-out (address 1) take effect only while the window is open. The window opens when 0xC1A5 and then 0x5E3B are written to address 3, the second word within UNLOCK_GAP cycles after the first. Writes made outside the window have no effect and cause no reset.
- R6: A write to address 3 whose data is not the expected key (wrong word, wrong order, or a second word arriving too late) raises `rst_req` at the very next edge (interrupt first if enabled).
- R7: If no time-out write follows within WCT counted cycles of the second unlock word, a reset is raised WCT cycles after that word. Cycles with `bus_gated` high are not counted.
- R8: In wait mode the counter holds its value unless bit 3 (wait enable) is set.
- R9: In stop mode the counter advances only if bit 4 (stop enable) is set and bit 1 is 0 (low-power source). Reset comes after two full time-outs (2*T ticks), with no interrupt whatever bit 2 says, and the reset counter is unchanged.
- R10: With bit 5 (debug pause) set, the count freezes in debug and resumes from the frozen value on exit. Refresh still works in debug, and the configuration window is still enforced in debug.
- R11: With bit 1 = 0, the counter advances only on cycles where `lp_tick` is high.
- R12: With bit 0 (enable) clear, no time-out ever occurs and the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| lp_tick | input | 1 | Low-power clock tick enable |
| wait_mode | input | 1 | System is in wait mode |
| stop_mode | input | 1 | System is in stop mode |
| dbg_mode | input | 1 | System is in debug mode |
| bus_gated | input | 1 | Bus clock considered gated |
| irq | output | 1 | Interrupt request before reset |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Writes and key errors take effect on the edge that samples them. An unlock error therefore shows on `rst_req` immediately after that edge, a time-out shows T counted edges after the restart edge, and the end of the interrupt window shows IRQ_DLY edges later still. The bench counts edges from the restart write and samples one time unit after each edge, so every latency is compared as an exact edge count. Register reads are combinational and are sampled mid-cycle. Stop-mode, low-power and pause cases are measured the same way, with the expected count worked out from the tick pattern the bench itself drives.

// File: rtl/modewdt_pkg.sv
package modewdt_pkg;

  localparam logic [2:0] A_CTRL    = 3'd0;
  localparam logic [2:0] A_TOVAL   = 3'd1;
  localparam logic [2:0] A_REFRESH = 3'd2;
  localparam logic [2:0] A_UNLOCK  = 3'd3;
  localparam logic [2:0] A_RSTCNT  = 3'd4;
  localparam logic [2:0] A_COUNT   = 3'd5;

  localparam logic [15:0] KEY_A       = 16'hC1A5;
  localparam logic [15:0] KEY_B       = 16'h5E3B;
  localparam logic [15:0] KEY_REFRESH = 16'h7D9A;
  localparam logic [15:0] RC_CLEAR    = 16'hFFFF;

  typedef struct packed {
    logic dbg_pause;
    logic stop_en;
    logic wait_en;
    logic irq_en;
    logic bus_sel;
    logic en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 6'b000011;

  typedef enum logic [1:0] {UL_IDLE, UL_WAIT_B, UL_OPEN} ul_state_e;

  // time-out reached when the next tick would pass the programmed value
  function automatic logic hit_limit(input logic [15:0] cnt, input logic [15:0] lim);
    return (lim == 16'd0) ? 1'b1 : (cnt >= lim - 16'd1);
  endfunction

  // whether the current power/debug mode lets the counter advance
  function automatic logic mode_allows(input ctrl_t c, input logic wt, input logic st,
                                       input logic dbg);
    logic ok;
    ok = 1'b1;
    if (st && !(c.stop_en && !c.bus_sel)) ok = 1'b0;
    if (wt && !c.wait_en) ok = 1'b0;
    if (dbg && c.dbg_pause) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/modewdt_unlock.sv
module modewdt_unlock
  import modewdt_pkg::*;
#(
  parameter int WCT = 256,
  parameter int UNLOCK_GAP = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_gated,
  input  logic        key_wr,
  input  logic [15:0] key_data,
  input  logic        cfg_done,
  output logic        win_open,
  output logic        exc
);
  localparam int MAXW = (WCT > UNLOCK_GAP) ? WCT : UNLOCK_GAP;
  localparam int TW = $clog2(MAXW + 1);

  ul_state_e st;
  logic [TW-1:0] tmr;
  logic bad_key, win_miss, gap_end;

  assign bad_key  = key_wr && ((st == UL_WAIT_B) ? (key_data != KEY_B) : (key_data != KEY_A));
  assign gap_end  = (st == UL_WAIT_B) && !key_wr && (tmr == TW'(UNLOCK_GAP - 1));
  assign win_miss = (st == UL_OPEN) && !bus_gated && !cfg_done && !key_wr
                    && (tmr == TW'(WCT - 1));
  assign win_open = (st == UL_OPEN);
  assign exc      = bad_key | win_miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= UL_IDLE;
      tmr <= '0;
    end else if (key_wr) begin
      tmr <= '0;
      if (bad_key)               st <= UL_IDLE;
      else if (st == UL_WAIT_B)  st <= UL_OPEN;
      else                       st <= UL_WAIT_B;
    end else begin
      case (st)
        UL_WAIT_B: begin
          if (gap_end) st <= UL_IDLE;
          else         tmr <= tmr + TW'(1);
        end
        UL_OPEN: begin
          if (cfg_done || win_miss) st <= UL_IDLE;
          else if (!bus_gated)      tmr <= tmr + TW'(1);
        end
        default: tmr <= '0;
      endcase
    end
  end

  // R5
  win_open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(key_wr && key_data == KEY_B));

  // R7
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_miss |=> !win_open);

endmodule

// File: rtl/modewdt_timer.sv
module modewdt_timer
  import modewdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        restart,
  input  logic        flush,
  input  logic        stop_mode,
  input  logic [15:0] toval,
  output logic [15:0] cnt,
  output logic        norm_to,
  output logic        stop_to
);
  logic half;
  logic lim_hit;

  assign lim_hit = run && !restart && !flush && hit_limit(cnt, toval);
  assign norm_to = lim_hit && !stop_mode;
  assign stop_to = lim_hit && stop_mode && half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (restart || flush) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (run) begin
      if (lim_hit) begin
        cnt  <= '0;
        half <= stop_mode ? !half : 1'b0;
      end else begin
        cnt <= cnt + 16'd1;
      end
    end
  end

  // R8 R10 R12
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart && !flush) |=> $stable(cnt));

  // R9
  stop_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_to |-> !$past(stop_to));

endmodule

// File: rtl/modewdt_resp.sv
module modewdt_resp #(
  parameter int IRQ_DLY = 128,
  parameter int RCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              trig_stop,
  input  logic              irq_en,
  input  logic              rc_clr,
  output logic              irq,
  output logic              rst_req,
  output logic [RCNT_W-1:0] rcnt
);
  localparam int DW = $clog2(IRQ_DLY + 1);

  logic [DW-1:0] dly;
  logic busy;

  function automatic logic [RCNT_W-1:0] sat_inc(input logic [RCNT_W-1:0] v);
    return (&v) ? v : v + RCNT_W'(1);
  endfunction

  assign busy = irq || rst_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
      dly     <= '0;
      rcnt    <= '0;
    end else begin
      rst_req <= 1'b0;
      if (!busy && trig_stop) begin
        rst_req <= 1'b1;
      end else if (!busy && trig) begin
        if (irq_en) begin
          irq <= 1'b1;
          dly <= DW'(IRQ_DLY - 1);
        end else begin
          rst_req <= 1'b1;
          rcnt    <= sat_inc(rcnt);
        end
      end else if (irq) begin
        if (dly == '0) begin
          irq     <= 1'b0;
          rst_req <= 1'b1;
          rcnt    <= sat_inc(rcnt);
        end else begin
          dly <= dly - DW'(1);
        end
      end
      if (rc_clr) rcnt <= '0;
    end
  end

  // R2
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R3
  irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> rst_req);

  // R9
  stop_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_stop && !busy) |=> (rst_req && !irq));

  // R4
  rcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rcnt) |-> ((rcnt == $past(rcnt) + RCNT_W'(1)) || (rcnt == '0)));

endmodule

// File: rtl/modewdt_top.sv
module modewdt_top
  import modewdt_pkg::*;
#(
  parameter logic [15:0] TOVAL_RST = 16'h0100,
  parameter int WCT = 256,
  parameter int UNLOCK_GAP = 16,
  parameter int IRQ_DLY = 128,
  parameter int RCNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        lp_tick,
  input  logic        wait_mode,
  input  logic        stop_mode,
  input  logic        dbg_mode,
  input  logic        bus_gated,
  output logic        irq,
  output logic        rst_req
);
  ctrl_t ctrl;
  logic [15:0] toval;
  logic [15:0] cnt;
  logic [RCNT_W-1:0] rcnt;
  logic [15:0] rc_ext;

  logic win_open, exc;
  logic ctrl_wr, tov_wr, refresh, key_wr, rc_clr;
  logic src_tick, run;
  logic norm_to, stop_to;

  assign ctrl_wr  = wr_en && win_open && (addr == A_CTRL);
  assign tov_wr   = wr_en && win_open && (addr == A_TOVAL);
  assign refresh  = wr_en && (addr == A_REFRESH) && (wdata == KEY_REFRESH);
  assign key_wr   = wr_en && (addr == A_UNLOCK);
  assign rc_clr   = wr_en && (addr == A_RSTCNT) && (wdata == RC_CLEAR);
  assign src_tick = ctrl.bus_sel ? !bus_gated : lp_tick;
  assign run      = ctrl.en && src_tick && mode_allows(ctrl, wait_mode, stop_mode, dbg_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= CTRL_RST;
      toval <= TOVAL_RST;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(wdata[5:0]);
      if (tov_wr)  toval <= wdata;
    end
  end

  always_comb begin
    rc_ext = '0;
    rc_ext[RCNT_W-1:0] = rcnt;
    case (addr)
      A_CTRL:   rdata = {10'd0, ctrl};
      A_TOVAL:  rdata = toval;
      A_RSTCNT: rdata = rc_ext;
      A_COUNT:  rdata = cnt;
      default:  rdata = 16'd0;
    endcase
  end

  modewdt_unlock #(.WCT(WCT), .UNLOCK_GAP(UNLOCK_GAP)) unlock_i (
    .clk(clk), .rst_n(rst_n), .bus_gated(bus_gated), .key_wr(key_wr),
    .key_data(wdata), .cfg_done(tov_wr), .win_open(win_open), .exc(exc)
  );

  modewdt_timer timer_i (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(refresh || tov_wr),
    .flush(rst_req), .stop_mode(stop_mode), .toval(toval), .cnt(cnt),
    .norm_to(norm_to), .stop_to(stop_to)
  );

  modewdt_resp #(.IRQ_DLY(IRQ_DLY), .RCNT_W(RCNT_W)) resp_i (
    .clk(clk), .rst_n(rst_n), .trig(norm_to || exc), .trig_stop(stop_to),
    .irq_en(ctrl.irq_en), .rc_clr(rc_clr), .irq(irq), .rst_req(rst_req), .rcnt(rcnt)
  );

  // R5
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> $past(win_open));

endmodule

// File: tb/modewdt_top_tb_top.sv
module modewdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TOV0 = 16'd40;
  localparam int WIN = 12;
  localparam int GAP = 3;
  localparam int IDLY = 6;
  localparam int RCW = 4;

  localparam logic [2:0] R_CTRL = 3'd0, R_TOV = 3'd1, R_REF = 3'd2, R_KEY = 3'd3,
                         R_RC = 3'd4, R_CNT = 3'd5;
  localparam logic [15:0] K1 = 16'hC1A5, K2 = 16'h5E3B, KR = 16'h7D9A;

  typedef struct packed {
    logic [15:0] tov;
    logic [5:0]  ctl;
    logic [15:0] exp_irq;
    logic [15:0] exp_rst;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'd1,  6'd3, 16'd0, 16'd1},
    '{16'd3,  6'd3, 16'd0, 16'd3},
    '{16'd17, 6'd3, 16'd0, 16'd17},
    '{16'd5,  6'd7, 16'd5, 16'd11},
    '{16'd2,  6'd7, 16'd2, 16'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic lp_tick = 1'b0, wait_mode = 1'b0, stop_mode = 1'b0, dbg_mode = 1'b0;
  logic bus_gated = 1'b0;
  logic irq, rst_req;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  modewdt_top #(.TOVAL_RST(TOV0), .WCT(WIN), .UNLOCK_GAP(GAP), .IRQ_DLY(IDLY),
                .RCNT_W(RCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lp_tick(lp_tick), .wait_mode(wait_mode), .stop_mode(stop_mode),
    .dbg_mode(dbg_mode), .bus_gated(bus_gated), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    rst_n = 1'b0; wr_en = 1'b0; addr = 3'd0; wdata = 16'd0; lp_tick = 1'b0;
    wait_mode = 1'b0; stop_mode = 1'b0; dbg_mode = 1'b0; bus_gated = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic cfg(input logic [5:0] c, input logic [15:0] t);
    wr(R_KEY, K1);
    wr(R_KEY, K2);
    wr(R_CTRL, {10'd0, c});
    wr(R_TOV, t);
  endtask

  task automatic run_until_rst(input int start_n, input int limit, input int lp_per,
                               output int n_rst, output int n_irq, output int irq_len);
    int n;
    n = start_n; n_rst = -1; n_irq = -1; irq_len = 0;
    while (n < limit) begin
      if (lp_per > 0) lp_tick = ((n + 1) % lp_per == 0);
      @(posedge clk);
      #1;
      n++;
      if (irq) begin
        irq_len++;
        if (n_irq < 0) n_irq = n;
      end
      if (rst_req) begin
        n_rst = n;
        break;
      end
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      #1;
      if (rst_req) seen++;
    end
    chk(req, seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, nr, ni, il;

    // R1 reset state
    hw_reset();
    chk("R1 irq", int'(irq), 0);
    chk("R1 rst_req", int'(rst_req), 0);
    rd(R_CTRL, v); chk("R1 ctrl", v, 3);
    rd(R_TOV, v);  chk("R1 toval", v, int'(TOV0));
    rd(R_RC, v);   chk("R1 rstcnt", v, 0);

    // R2 R3 vector table
    for (int k = 0; k < NV; k++) begin
      hw_reset();
      cfg(VECS[k].ctl, VECS[k].tov);
      run_until_rst(0, 300, 0, nr, ni, il);
      chk((VECS[k].exp_irq == 0) ? "R2 reset latency" : "R3 reset latency", nr,
          int'(VECS[k].exp_rst));
      if (VECS[k].exp_irq == 0) begin
        chk("R2 no irq", il, 0);
      end else begin
        chk("R3 irq start", ni, int'(VECS[k].exp_irq));
        chk("R3 irq length", il, IDLY);
      end
      @(posedge clk); #1;
      chk("R2 single pulse", int'(rst_req), 0);
    end

    // R5 writes outside window ignored
    hw_reset();
    wr(R_CTRL, 16'd0);
    wr(R_TOV, 16'd5);
    chk("R5 no reset", int'(rst_req), 0);
    rd(R_CTRL, v); chk("R5 ctrl kept", v, 3);
    rd(R_TOV, v);  chk("R5 toval kept", v, int'(TOV0));

    // R5 second key after one idle cycle still opens window
    hw_reset();
    wr(R_KEY, K1);
    @(posedge clk);
    wr(R_KEY, K2);
    wr(R_TOV, 16'd33);
    rd(R_TOV, v); chk("R5 toval accepted", v, 33);

    // R6 bad key word
    hw_reset();
    wr(R_KEY, 16'h1111);
    chk("R6 bad word reset", int'(rst_req), 1);
    rd(R_RC, v); chk("R6 rstcnt", v, 1);
    hw_reset();
    wr(R_KEY, K2);
    chk("R6 wrong order", int'(rst_req), 1);
    hw_reset();
    wr(R_KEY, K1);
    repeat (4) @(posedge clk);
    wr(R_KEY, K2);
    chk("R6 late second word", int'(rst_req), 1);

    // R7 window miss, plain
    hw_reset();
    wr(R_KEY, K1); wr(R_KEY, K2);
    run_until_rst(0, 100, 0, nr, ni, il);
    chk("R7 window miss", nr, WIN);

    // R7 window pauses while bus gated
    hw_reset();
    wr(R_KEY, K1); wr(R_KEY, K2);
    bus_gated = 1'b1;
    quiet(5, "R7 gated no reset");
    bus_gated = 1'b0;
    run_until_rst(5, 100, 0, nr, ni, il);
    chk("R7 gated miss", nr, WIN + 5);

    // R10 window enforced in debug
    hw_reset();
    dbg_mode = 1'b1;
    wr(R_KEY, K1); wr(R_KEY, K2);
    run_until_rst(0, 100, 0, nr, ni, il);
    chk("R10 debug window", nr, WIN);

    // R8 wait without and with wait enable
    hw_reset();
    cfg(6'd3, 16'd10);
    wait_mode = 1'b1;
    quiet(30, "R8 wait pause");
    rd(R_CNT, v); chk("R8 count held", v, 0);
    wait_mode = 1'b0;
    run_until_rst(0, 100, 0, nr, ni, il);
    chk("R8 resume", nr, 10);
    hw_reset();
    cfg(6'd11, 16'd10);
    wait_mode = 1'b1;
    run_until_rst(0, 100, 0, nr, ni, il);
    chk("R8 wait enabled", nr, 10);

    // R11 low-power ticks every third cycle
    hw_reset();
    cfg(6'd1, 16'd4);
    run_until_rst(0, 100, 3, nr, ni, il);
    chk("R11 lp latency", nr, 12);
    lp_tick = 1'b0;

    // R9 stop: double time-out, no irq, counter unchanged
    hw_reset();
    cfg(6'd21, 16'd5);
    stop_mode = 1'b1; lp_tick = 1'b1;
    run_until_rst(0, 100, 0, nr, ni, il);
    chk("R9 double timeout", nr, 10);
    chk("R9 no irq", il, 0);
    rd(R_RC, v); chk("R9 rstcnt unchanged", v, 0);
    hw_reset();
    cfg(6'd19, 16'd5);
    stop_mode = 1'b1; lp_tick = 1'b1;
    quiet(40, "R9 bus source stops");
    hw_reset();
    cfg(6'd1, 16'd5);
    stop_mode = 1'b1; lp_tick = 1'b1;
    quiet(40, "R9 stop disabled");

    // R10 debug pause and refresh
    hw_reset();
    cfg(6'd35, 16'd10);
    repeat (4) @(posedge clk);
    #1;
    dbg_mode = 1'b1;
    quiet(20, "R10 paused");
    rd(R_CNT, v); chk("R10 frozen count", v, 4);
    wr(R_REF, KR);
    rd(R_CNT, v); chk("R10 refresh in debug", v, 0);
    dbg_mode = 1'b0;
    run_until_rst(0, 100, 0, nr, ni, il);
    chk("R10 resume", nr, 10);

    // R12 disabled
    hw_reset();
    cfg(6'd2, 16'd3);
    quiet(30, "R12 disabled");
    rd(R_CNT, v); chk("R12 count zero", v, 0);

    // R4 reset counter increments, saturates, clears
    hw_reset();
    cfg(6'd3, 16'd2);
    run_until_rst(0, 50, 0, nr, ni, il);
    rd(R_RC, v); chk("R4 first increment", v, 1);
    for (int p = 0; p < 19; p++) run_until_rst(0, 50, 0, nr, ni, il);
    rd(R_RC, v); chk("R4 saturated", v, 15);
    cfg(6'd2, 16'd40);
    wr(R_RC, 16'h1234);
    rd(R_RC, v); chk("R4 other data ignored", v, 15);
    wr(R_RC, 16'hFFFF);
    rd(R_RC, v); chk("R4 cleared", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule